// File: doc/BRIEF.md
# Bit-Slice Arithmetic and Logic Unit

A purely combinational arithmetic and logic unit for the execute stage of a small load/store processor. It takes two 32-bit operands and a 4-bit operation code. It returns a 32-bit result, a carry-out, a signed-overflow flag and a zero flag, all in the same cycle.

The datapath is a row of identical one-bit slices. Each slice holds a full adder, an optional inverter on its second operand, and a result selector. Subtraction reuses the adder as A + ~B + 1. Both set-less-than operations use that subtract path. Logic at the top slice derives overflow and the two less-than decisions, and the chosen decision is fed back into bit 0 of the result.

Top module: `slice_alu`

## Requirements
- R1: Code 0 (signed add) and code 1 (unsigned add) give result = A + B modulo 2^32.
- R2: Code 2 (signed subtract) and code 3 (unsigned subtract) give result = A − B modulo 2^32, computed as A + ~B + 1.
- R3: The overflow flag equals the carry into bit 31 XOR the carry out of bit 31, and it is raised only for codes 0 and 2. For code 0 it is 1 exactly when A and B have the same sign and the result sign differs from it. For code 2 it is 1 exactly when A and B have different signs and the result sign differs from A. For every other code it is 0.
- R4: For codes 0–3, carry_out is the carry out of bit 31 of the adder (for subtraction: 1 when no borrow, i.e. A ≥ B unsigned). For all other codes carry_out is 0.
- R5: Codes 4, 5, 6 and 7 give bitwise AND, OR, XOR and NOR of A and B.
- R6: Code 0xA gives result 1 (bit 0 set, bits 31:1 clear) when A < B as two's-complement values, else 0. The decision stays correct when A − B overflows.
- R7: Code 0xB gives result 1 when A < B as unsigned values, else 0. For example, A = all-ones and B = 1 gives 0 here but 1 under code 0xA.
- R8: zero is 1 exactly when all 32 result bits are 0.
- R9: Codes 8, 9 and 0xC–0xF give result 0, carry_out 0, overflow 0, and so zero = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op_code | input | 4 | Operation select |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Adder carry out of bit 31 for add/subtract codes |
| overflow | output | 1 | Signed overflow for codes 0 and 2 |
| zero | output | 1 | Result is all zeros |

## Verification
The bench runs every code over the operands 0, 1, all-ones, the most positive and the most negative values, plus random pairs, against an independent wide-arithmetic model.

The most-negative minus one case catches a set-less-than that uses only the sign of the difference; such a design reports the wrong ordering on overflow. The all-ones versus one pair catches swapped signed and unsigned compares. The add and subtract codes over the same operands catch an overflow flag that leaks into the unsigned codes. Subtracting equal values catches an inverted borrow sense on carry_out. The unused codes catch a selector default that passes adder output through.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_ADDU = 4'h1,
    OP_SUB  = 4'h2,
    OP_SUBU = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOR  = 4'h7,
    OP_SLT  = 4'hA,
    OP_SLTU = 4'hB
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_SUM  = 3'd0,
    SEL_AND  = 3'd1,
    SEL_OR   = 3'd2,
    SEL_XOR  = 3'd3,
    SEL_NOR  = 3'd4,
    SEL_LESS = 3'd5,
    SEL_NONE = 3'd6
  } res_sel_e;

  // full adder sum bit
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // full adder carry: generate, or propagate of incoming carry
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x | y));
  endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] op_code,
  output logic       b_invert,
  output res_sel_e   sel,
  output logic       arith,
  output logic       sovf_en,
  output logic       lt_signed
);
  always_comb begin
    b_invert  = 1'b0;
    sel       = SEL_NONE;
    arith     = 1'b0;
    sovf_en   = 1'b0;
    lt_signed = 1'b0;
    case (op_code)
      OP_ADD:  begin sel = SEL_SUM; arith = 1'b1; sovf_en = 1'b1; end
      OP_ADDU: begin sel = SEL_SUM; arith = 1'b1; end
      OP_SUB:  begin sel = SEL_SUM; arith = 1'b1; sovf_en = 1'b1; b_invert = 1'b1; end
      OP_SUBU: begin sel = SEL_SUM; arith = 1'b1; b_invert = 1'b1; end
      OP_AND:  sel = SEL_AND;
      OP_OR:   sel = SEL_OR;
      OP_XOR:  sel = SEL_XOR;
      OP_NOR:  sel = SEL_NOR;
      OP_SLT:  begin sel = SEL_LESS; b_invert = 1'b1; lt_signed = 1'b1; end
      OP_SLTU: begin sel = SEL_LESS; b_invert = 1'b1; end
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic     a,
  input  logic     b,
  input  logic     cin,
  input  logic     b_invert,
  input  logic     less,
  input  res_sel_e sel,
  output logic     sum,
  output logic     cout,
  output logic     res
);
  logic b_eff;

  assign b_eff = b ^ b_invert;
  assign sum   = fa_sum(a, b_eff, cin);
  assign cout  = fa_carry(a, b_eff, cin);

  always_comb begin
    case (sel)
      SEL_SUM:  res = sum;
      SEL_AND:  res = a & b;
      SEL_OR:   res = a | b;
      SEL_XOR:  res = a ^ b;
      SEL_NOR:  res = ~(a | b);
      SEL_LESS: res = less;
      default:  res = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_msb_logic.sv
module alu_msb_logic (
  input  logic c_into_msb,
  input  logic c_out_msb,
  input  logic sum_msb,
  output logic ovf_raw,
  output logic lt_s,
  output logic lt_u
);
  assign ovf_raw = c_into_msb ^ c_out_msb;
  // sign of difference corrected by overflow
  assign lt_s    = sum_msb ^ ovf_raw;
  // no carry out of A + ~B + 1 means a borrow occurred
  assign lt_u    = ~c_out_msb;
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum_bits;
  logic             b_invert, arith, sovf_en, lt_signed;
  res_sel_e         sel;
  logic             ovf_raw, lt_s, lt_u, less_bit;

  alu_decode u_dec (
    .op_code  (op_code),
    .b_invert (b_invert),
    .sel      (sel),
    .arith    (arith),
    .sovf_en  (sovf_en),
    .lt_signed(lt_signed)
  );

  assign carry[0] = b_invert;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = less_bit;
    end else begin : g_rest
      assign less_in = 1'b0;
    end
    alu_slice u_slice (
      .a       (opa[i]),
      .b       (opb[i]),
      .cin     (carry[i]),
      .b_invert(b_invert),
      .less    (less_in),
      .sel     (sel),
      .sum     (sum_bits[i]),
      .cout    (carry[i+1]),
      .res     (result[i])
    );
  end

  alu_msb_logic u_msb (
    .c_into_msb(carry[MSB]),
    .c_out_msb (carry[WIDTH]),
    .sum_msb   (sum_bits[MSB]),
    .ovf_raw   (ovf_raw),
    .lt_s      (lt_s),
    .lt_u      (lt_u)
  );

  assign less_bit  = lt_signed ? lt_s : lt_u;
  assign carry_out = arith & carry[WIDTH];
  assign overflow  = sovf_en & ovf_raw;
  assign zero      = ~|result;

  always_comb begin
    if (!$isunknown({opa, opb, op_code})) begin
      // R3: overflow only on signed add/sub
      assert_ovf_signed_only_R3: assert (!overflow || op_code == 4'h0 || op_code == 4'h2);
      // R3: signed add overflow means same-sign operands, result sign flipped
      if (op_code == 4'h0 && overflow)
        assert_add_ovf_sign_R3: assert (opa[MSB] == opb[MSB] && result[MSB] != opa[MSB]);
      // R4: no carry outside add/subtract
      assert_carry_arith_only_R4: assert (!carry_out || op_code < 4'h4);
      // R6 R7: compares set only bit 0
      if (op_code == 4'hA || op_code == 4'hB)
        assert_slt_upper_clear_R6: assert (result[MSB:1] == '0);
      // R9: unused codes produce nothing
      if (op_code inside {4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF})
        assert_unused_quiet_R9: assert (result == '0 && !carry_out && !overflow && zero);
    end
  end
endmodule

// File: tb/test_slice_alu.sv
module test_slice_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opa = '0, opb = '0;
  logic [3:0]  op_code = 4'h0;
  logic [31:0] result;
  logic        carry_out, overflow, zero;

  int n_checks = 0, n_fail = 0;

  typedef struct {
    logic [31:0] r;
    logic        c, v, z;
    logic [3:0]  m;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  slice_alu i_slice_alu (
    .opa(opa), .opb(opb), .op_code(op_code),
    .result(result), .carry_out(carry_out), .overflow(overflow), .zero(zero)
  );

  function automatic string res_tag(input logic [3:0] m);
    case (m)
      4'h0, 4'h1: return "R1";
      4'h2, 4'h3: return "R2";
      4'h4, 4'h5, 4'h6, 4'h7: return "R5";
      4'hA: return "R6";
      4'hB: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m);
    exp_t e;
    logic [32:0] w;
    e.r = '0; e.c = 1'b0; e.v = 1'b0; e.m = m;
    case (m)
      4'h0, 4'h1: begin
        w = {1'b0, a} + {1'b0, b};
        e.r = w[31:0]; e.c = w[32];
        e.v = (m == 4'h0) && (a[31] == b[31]) && (e.r[31] != a[31]);
      end
      4'h2, 4'h3: begin
        e.r = a - b; e.c = (a >= b);
        e.v = (m == 4'h2) && (a[31] != b[31]) && (e.r[31] != a[31]);
      end
      4'h4: e.r = a & b;
      4'h5: e.r = a | b;
      4'h6: e.r = a ^ b;
      4'h7: e.r = ~(a | b);
      4'hA: e.r = {31'd0, ($signed(a) < $signed(b))};
      4'hB: e.r = {31'd0, (a < b)};
      default: e.r = '0;
    endcase
    e.z = (e.r == 32'd0);
    return e;
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m);
    @(posedge clk);
    #1;
    opa = a; opb = b; op_code = m;
    exp_q.push_back(model(a, b, m));
    tag_q.push_back(res_tag(m));
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h a=%h b=%h actual=%h expected=%h", tag, op_code, opa, opb, act, exp);
    end
  endtask

  // monitor: pops one expectation per cycle, mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, result, e.r);
      check("R4", {31'd0, carry_out}, {31'd0, e.c});
      check("R3", {31'd0, overflow}, {31'd0, e.v});
      check("R8", {31'd0, zero}, {31'd0, e.z});
    end
  end

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h8000_0000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time state with all-zero inputs: add gives 0, zero flag set (R1, R8)
    @(negedge clk);
    check("R1", result, 32'd0);
    check("R8", {31'd0, zero}, 32'd1);
    // R7 vs R6 example: all-ones < 1
    drive(32'hFFFF_FFFF, 32'd1, 4'hA);
    drive(32'hFFFF_FFFF, 32'd1, 4'hB);
    // R6 under overflowing subtraction
    drive(32'h8000_0000, 32'd1, 4'hA);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'hA);
    // R3: unsigned add with the same carries must not flag
    drive(32'h7FFF_FFFF, 32'd1, 4'h1);
    drive(32'h7FFF_FFFF, 32'd1, 4'h0);
    // R4: equal subtract gives carry 1
    drive(32'h1234_5678, 32'h1234_5678, 4'h3);
    for (int m = 0; m < 16; m++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(corner[i], corner[j], 4'(m));
    for (int k = 0; k < 3000; k++)
      drive($urandom, $urandom, 4'($urandom));
    @(posedge clk);
    @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule